// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the part of a small 16-bit processor core that carries out the three control transfers tied to interrupts: a software interrupt raised by an instruction, a keyboard interrupt raised by an input event, and the return from a handler. When a request is accepted, the block copies the current code-segment, instruction-pointer, stack-pointer and flags values. It then runs a fixed series of word transfers on a request/acknowledge memory port. At the end it presents the new register values, and a fault indication when the request was refused.

An entry checks the interrupt-enable flag first. Next it reads the length word at the base of the vector table and checks the vector number against it, then fetches the handler address. It pushes the code segment and then the instruction pointer onto a stack that grows toward higher addresses. Last, it sets the code segment to zero and jumps to the handler. A return pops the instruction pointer and then the code segment. A hold-off counter limits how often keyboard events are taken. The core pulses `retire` once per executed instruction, and each pulse counts the hold-off down.

Top module: `intr_seq`

## Requirements
- R1: A software interrupt taken while flag bit 2 (interrupt enable) of `fl_in` is clear makes no memory access. It ends with `done` and `fault` high, `fl_out` equal to `fl_in` with bit 3 (error) set, and `cs_out`, `ip_out` and `sp_out` equal to their inputs.
- R2: Entry reads the word at `tbl_base` as the entry count. A vector number at or above that count makes no further access and ends with `fault` high, error bit 3 set in `fl_out`, and the other outputs equal to their inputs.
- R3: The handler address for vector n is read from byte address `tbl_base + 2*n + 2`.
- R4: Entry writes `cs_in` to address `sp_in + 2` and then `ip_in` to `sp_in + 4`, and ends with `sp_out = sp_in + 4`.
- R5: A successful entry ends with `cs_out = 0`, `ip_out` equal to the handler address, `fl_out = fl_in` and `fault` low.
- R6: A return reads `ip_out` from address `sp_in` and then `cs_out` from `sp_in - 2`, makes no write, and ends with `sp_out = sp_in - 4`.
- R7: A keyboard event accepted while the hold-off count is zero and interrupts are enabled runs an entry for vector 0. On completion it latches `kbd_code` into `kbd_port` and reloads the hold-off count to 10.
- R8: The hold-off count falls by one for each `retire` pulse and stops at zero. A keyboard event that arrives while the count is non-zero, or while the enable bit is clear, is dropped: `busy` and `done` stay low and `kbd_port` keeps its value.
- R9: `mem_req` stays high with a stable address and write data until `mem_ack`, and one word moves per acknowledge. `busy` is high while a sequence is in progress. `done` is a one-cycle pulse with `busy` low. After reset `busy`, `done`, `mem_req` and `kbd_port` are zero.
- R10: Requests are taken only when idle. Requests that arrive while busy are ignored. When several requests arrive together, a return goes first, then a software interrupt, then a keyboard event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_req | input | 1 | Start an interrupt return |
| sw_req | input | 1 | Start a software interrupt |
| sw_vec | input | 8 | Vector number of the software interrupt |
| kbd_req | input | 1 | Keyboard event |
| kbd_code | input | 16 | Key code carried by the event |
| retire | input | 1 | One pulse per executed instruction |
| tbl_base | input | 16 | Byte address of the vector table |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer |
| sp_in | input | 16 | Current stack pointer |
| fl_in | input | 16 | Current flags |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 16 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Transfer acknowledge |
| mem_rdata | input | 16 | Read data, valid with acknowledge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished, outputs valid |
| fault | output | 1 | Request refused, valid with done |
| cs_out | output | 16 | Resulting code segment |
| ip_out | output | 16 | Resulting instruction pointer |
| sp_out | output | 16 | Resulting stack pointer |
| fl_out | output | 16 | Resulting flags |
| kbd_port | output | 16 | Last accepted key code |

## Verification
The bench uses the defaults: 16-bit words, 8-bit vectors, enable on bit 2, error on bit 3 and a hold-off reload of 10. A reload of 10 lets the bench walk the whole hold-off window one pulse at a time, so it can show an event dropped at a count of one and accepted at zero. The bench memory answers after 0, 1 or 2 wait states. These wait times keep requests pending across several cycles, and they make the simultaneous-request case run long enough that a request arriving while busy lands inside a live sequence. The vector table holds three entries, so both the last valid vector and the first out-of-range vector can be reached.

// File: rtl/intr_pkg.sv
package intr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RD_CNT, S_RD_VEC, S_WR_CS, S_WR_IP, S_RD_IP, S_RD_CS, S_FIN
  } seq_state_t;

  typedef enum logic [1:0] {K_SW, K_KBD, K_RET} req_kind_t;
endpackage

// File: rtl/intr_rst_sync.sv
module intr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/intr_holdoff.sv
module intr_holdoff #(
  parameter int RELOAD = 10,
  localparam int CW = $clog2(RELOAD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dec,
  input  logic load,
  output logic ready
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = CW'(RELOAD);
      cnt_en = 1'b1;
    end else if (dec && cnt_q != '0) begin
      cnt_d  = cnt_q - CW'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready = (cnt_q == '0);
endmodule

// File: rtl/intr_fsm.sv
module intr_fsm
  import intr_pkg::*;
#(
  parameter int W       = 16,
  parameter int VEC_W   = 8,
  parameter int IEN_BIT = 2,
  parameter int ERR_BIT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ret_req,
  input  logic             sw_req,
  input  logic [VEC_W-1:0] sw_vec,
  input  logic             kbd_req,
  input  logic [W-1:0]     kbd_code,
  input  logic             ho_ready,
  input  logic [W-1:0]     tbl_base,
  input  logic [W-1:0]     cs_in,
  input  logic [W-1:0]     ip_in,
  input  logic [W-1:0]     sp_in,
  input  logic [W-1:0]     fl_in,
  output logic             mem_req,
  output logic             mem_we,
  output logic [W-1:0]     mem_addr,
  output logic [W-1:0]     mem_wdata,
  input  logic             mem_ack,
  input  logic [W-1:0]     mem_rdata,
  output logic             ho_load,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic [W-1:0]     cs_out,
  output logic [W-1:0]     ip_out,
  output logic [W-1:0]     sp_out,
  output logic [W-1:0]     fl_out,
  output logic [W-1:0]     kbd_port
);
  localparam logic [W-1:0] STEP = W'(2);

  seq_state_t       st_q, st_d;
  req_kind_t        kind_q, kind_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic [W-1:0]     cs_q, cs_d, ip_q, ip_d, sp_q, sp_d, fl_q, fl_d;
  logic [W-1:0]     hnd_q, hnd_d, key_q, key_d, kport_q, kport_d;
  logic             flt_q, flt_d;
  logic [W-1:0]     vec_ext, vec_off;

  assign vec_ext = {{(W-VEC_W){1'b0}}, vec_q};
  assign vec_off = {{(W-VEC_W-1){1'b0}}, vec_q, 1'b0};

  always_comb begin
    st_d = st_q;  kind_d = kind_q; vec_d = vec_q;
    cs_d = cs_q;  ip_d = ip_q; sp_d = sp_q; fl_d = fl_q;
    hnd_d = hnd_q; key_d = key_q; kport_d = kport_q; flt_d = flt_q;
    ho_load = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (ret_req || sw_req || (kbd_req && ho_ready && fl_in[IEN_BIT])) begin
          cs_d = cs_in; ip_d = ip_in; sp_d = sp_in; fl_d = fl_in;
          flt_d = 1'b0;
        end
        if (ret_req) begin
          kind_d = K_RET;
          st_d   = S_RD_IP;
        end else if (sw_req) begin
          kind_d = K_SW;
          vec_d  = sw_vec;
          if (!fl_in[IEN_BIT]) begin
            fl_d[ERR_BIT] = 1'b1;
            flt_d         = 1'b1;
            st_d          = S_FIN;
          end else begin
            st_d = S_RD_CNT;
          end
        end else if (kbd_req && ho_ready && fl_in[IEN_BIT]) begin
          kind_d = K_KBD;
          vec_d  = '0;
          key_d  = kbd_code;
          st_d   = S_RD_CNT;
        end
      end
      S_RD_CNT: if (mem_ack) begin
        if (vec_ext >= mem_rdata) begin
          fl_d[ERR_BIT] = 1'b1;
          flt_d         = 1'b1;
          st_d          = S_FIN;
        end else begin
          st_d = S_RD_VEC;
        end
      end
      S_RD_VEC: if (mem_ack) begin
        hnd_d = mem_rdata;
        st_d  = S_WR_CS;
      end
      S_WR_CS: if (mem_ack) begin
        sp_d = sp_q + STEP;
        st_d = S_WR_IP;
      end
      S_WR_IP: if (mem_ack) begin
        sp_d = sp_q + STEP;
        cs_d = '0;
        ip_d = hnd_q;
        st_d = S_FIN;
        if (kind_q == K_KBD) begin
          kport_d = key_q;
          ho_load = 1'b1;
        end
      end
      S_RD_IP: if (mem_ack) begin
        ip_d = mem_rdata;
        sp_d = sp_q - STEP;
        st_d = S_RD_CS;
      end
      S_RD_CS: if (mem_ack) begin
        cs_d = mem_rdata;
        sp_d = sp_q - STEP;
        st_d = S_FIN;
      end
      S_FIN:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st_q)
      S_RD_CNT: begin mem_req = 1'b1; mem_addr = tbl_base; end
      S_RD_VEC: begin mem_req = 1'b1; mem_addr = tbl_base + vec_off + STEP; end
      S_WR_CS:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp_q + STEP; mem_wdata = cs_q; end
      S_WR_IP:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp_q + STEP; mem_wdata = ip_q; end
      S_RD_IP,
      S_RD_CS:  begin mem_req = 1'b1; mem_addr = sp_q; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; kind_q <= K_SW; vec_q <= '0;
      cs_q <= '0; ip_q <= '0; sp_q <= '0; fl_q <= '0;
      hnd_q <= '0; key_q <= '0; kport_q <= '0; flt_q <= 1'b0;
    end else begin
      st_q <= st_d; kind_q <= kind_d; vec_q <= vec_d;
      cs_q <= cs_d; ip_q <= ip_d; sp_q <= sp_d; fl_q <= fl_d;
      hnd_q <= hnd_d; key_q <= key_d; kport_q <= kport_d; flt_q <= flt_d;
    end
  end

  assign busy     = (st_q != S_IDLE) && (st_q != S_FIN);
  assign done     = (st_q == S_FIN);
  assign fault    = done && flt_q;
  assign cs_out   = cs_q;
  assign ip_out   = ip_q;
  assign sp_out   = sp_q;
  assign fl_out   = fl_q;
  assign kbd_port = kport_q;
endmodule

// File: rtl/intr_seq.sv
module intr_seq #(
  parameter int W       = 16,
  parameter int VEC_W   = 8,
  parameter int IEN_BIT = 2,
  parameter int ERR_BIT = 3,
  parameter int HOLDOFF = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ret_req,
  input  logic             sw_req,
  input  logic [VEC_W-1:0] sw_vec,
  input  logic             kbd_req,
  input  logic [W-1:0]     kbd_code,
  input  logic             retire,
  input  logic [W-1:0]     tbl_base,
  input  logic [W-1:0]     cs_in,
  input  logic [W-1:0]     ip_in,
  input  logic [W-1:0]     sp_in,
  input  logic [W-1:0]     fl_in,
  output logic             mem_req,
  output logic             mem_we,
  output logic [W-1:0]     mem_addr,
  output logic [W-1:0]     mem_wdata,
  input  logic             mem_ack,
  input  logic [W-1:0]     mem_rdata,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic [W-1:0]     cs_out,
  output logic [W-1:0]     ip_out,
  output logic [W-1:0]     sp_out,
  output logic [W-1:0]     fl_out,
  output logic [W-1:0]     kbd_port
);
  logic rst_n_s, ho_ready, ho_load;

  intr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  intr_holdoff #(.RELOAD(HOLDOFF)) u_hold (
    .clk(clk), .rst_n(rst_n_s), .dec(retire), .load(ho_load), .ready(ho_ready)
  );

  intr_fsm #(.W(W), .VEC_W(VEC_W), .IEN_BIT(IEN_BIT), .ERR_BIT(ERR_BIT)) u_fsm (
    .clk(clk), .rst_n(rst_n_s),
    .ret_req(ret_req), .sw_req(sw_req), .sw_vec(sw_vec),
    .kbd_req(kbd_req), .kbd_code(kbd_code), .ho_ready(ho_ready),
    .tbl_base(tbl_base), .cs_in(cs_in), .ip_in(ip_in), .sp_in(sp_in), .fl_in(fl_in),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .ho_load(ho_load),
    .busy(busy), .done(done), .fault(fault),
    .cs_out(cs_out), .ip_out(ip_out), .sp_out(sp_out), .fl_out(fl_out),
    .kbd_port(kbd_port)
  );
endmodule

// File: rtl/intr_seq_chk.sv
module intr_seq_chk #(
  parameter int W       = 16,
  parameter int ERR_BIT = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mem_req,
  input logic         mem_ack,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_wdata,
  input logic         busy,
  input logic         done,
  input logic         fault,
  input logic [W-1:0] fl_out,
  input logic [W-1:0] kbd_port
);
  // R9: a pending request keeps its address and data
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

  // R9: memory traffic only inside a sequence
  a_r9_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: the cycle after done no transfer is pending
  a_r9_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !mem_req);

  // R1, R2: a refused request reports the error flag
  a_r2_fault_err: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (done && fl_out[ERR_BIT]));

  // R7, R8: the key port changes only at the end of a sequence
  a_r8_port_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(kbd_port) |-> done);
endmodule

bind intr_seq intr_seq_chk #(.W(W), .ERR_BIT(ERR_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .done(done),
  .fault(fault), .fl_out(fl_out), .kbd_port(kbd_port)
);

// File: tb/intr_seq_tb.sv
module intr_seq_tb;
  localparam int W = 16;
  localparam logic [15:0] IEN = 16'h0004;
  localparam logic [15:0] ERR = 16'h0008;
  localparam logic [15:0] BASE = 16'h0100;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, ret_req, sw_req, kbd_req, retire, mem_ack;
  logic [7:0] sw_vec;
  logic [15:0] kbd_code, tbl_base, cs_in, ip_in, sp_in, fl_in, mem_rdata;
  logic mem_req, mem_we, busy, done, fault;
  logic [15:0] mem_addr, mem_wdata, cs_out, ip_out, sp_out, fl_out, kbd_port;

  intr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ret_req(ret_req), .sw_req(sw_req), .sw_vec(sw_vec),
    .kbd_req(kbd_req), .kbd_code(kbd_code), .retire(retire), .tbl_base(tbl_base),
    .cs_in(cs_in), .ip_in(ip_in), .sp_in(sp_in), .fl_in(fl_in),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done), .fault(fault),
    .cs_out(cs_out), .ip_out(ip_out), .sp_out(sp_out), .fl_out(fl_out),
    .kbd_port(kbd_port)
  );

  int checks = 0, fails = 0;
  int waitst = 0, wcnt = 0, done_cnt = 0, bh = 0;
  logic [15:0] mem [int];
  logic [15:0] qa[$], qd[$];
  logic        qw[$];
  string       qt[$];
  logic [15:0] e_cs, e_ip, e_sp, e_fl, e_port;
  logic        e_fault;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rd(logic [15:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 16'h0;
  endfunction

  task automatic expect_acc(string tag, logic [15:0] a, logic we, logic [15:0] d);
    qa.push_back(a); qw.push_back(we); qd.push_back(d); qt.push_back(tag);
  endtask

  // memory model and access monitor: every acknowledged word is compared
  always @(negedge clk) begin
    if (done === 1'b1) done_cnt++;
    if (mem_ack) begin
      mem_ack = 1'b0;
      wcnt = waitst;
    end else if (rst_n && mem_req === 1'b1) begin
      if (wcnt == 0) begin
        mem_ack = 1'b1;
        mem_rdata = rd(mem_addr);
        if (qa.size() == 0) chk("R9 unexpected access", 1, 0);
        else begin
          automatic string t = qt.pop_front();
          chk({t, " addr"}, mem_addr, qa.pop_front());
          chk({t, " dir"}, mem_we, qw.pop_front());
          if (mem_we) chk({t, " wdata"}, mem_wdata, qd.pop_front());
          else void'(qd.pop_front());
        end
        if (mem_we) mem[int'(mem_addr)] = mem_wdata;
      end else wcnt--;
    end
  end

  task automatic wait_done(string tag);
    int n = 0;
    while (done !== 1'b1 && n < 200) begin @(negedge clk); n++; end
    chk({tag, " done seen"}, done, 1);
    chk({tag, " busy low at done"}, busy, 0);
    chk({tag, " fault"}, fault, e_fault);
    chk({tag, " cs_out"}, cs_out, e_cs);
    chk({tag, " ip_out"}, ip_out, e_ip);
    chk({tag, " sp_out"}, sp_out, e_sp);
    chk({tag, " fl_out"}, fl_out, e_fl);
    chk({tag, " kbd_port"}, kbd_port, e_port);
    chk({tag, " all accesses made"}, qa.size(), 0);
    qa.delete(); qw.delete(); qd.delete(); qt.delete();
  endtask

  task automatic set_ctx(logic [15:0] c, logic [15:0] i, logic [15:0] s, logic [15:0] f);
    cs_in = c; ip_in = i; sp_in = s; fl_in = f;
  endtask

  // expected entry behaviour for vector v from the current inputs
  task automatic plan_entry(string tag, int v);
    e_cs = cs_in; e_ip = ip_in; e_sp = sp_in; e_fl = fl_in; e_fault = 1'b0;
    if ((fl_in & IEN) == 0) begin
      e_fl = fl_in | ERR; e_fault = 1'b1;
      return;
    end
    expect_acc({tag, " R2 count read"}, BASE, 0, 0);
    if (v >= int'(rd(BASE))) begin
      e_fl = fl_in | ERR; e_fault = 1'b1;
      return;
    end
    expect_acc({tag, " R3 vector read"}, BASE + 16'(2 * v + 2), 0, 0);
    expect_acc({tag, " R4 push cs"}, sp_in + 16'd2, 1, cs_in);
    expect_acc({tag, " R4 push ip"}, sp_in + 16'd4, 1, ip_in);
    e_cs = 16'h0; e_ip = rd(BASE + 16'(2 * v + 2)); e_sp = sp_in + 16'd4;
  endtask

  task automatic do_sw(string tag, logic [7:0] v);
    @(negedge clk);
    sw_vec = v;
    plan_entry(tag, int'(v));
    sw_req = 1'b1;
    @(negedge clk);
    sw_req = 1'b0;
    wait_done(tag);
  endtask

  task automatic do_ret(string tag);
    @(negedge clk);
    expect_acc({tag, " R6 pop ip"}, sp_in, 0, 0);
    expect_acc({tag, " R6 pop cs"}, sp_in - 16'd2, 0, 0);
    e_ip = rd(sp_in); e_cs = rd(sp_in - 16'd2); e_sp = sp_in - 16'd4;
    e_fl = fl_in; e_fault = 1'b0;
    ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
    wait_done(tag);
  endtask

  task automatic do_kbd(string tag, logic [15:0] code);
    int d0;
    @(negedge clk);
    kbd_code = code;
    if (bh == 0 && (fl_in & IEN) != 0) begin
      plan_entry(tag, 0);
      e_port = code;
      kbd_req = 1'b1;
      @(negedge clk);
      kbd_req = 1'b0;
      wait_done(tag);
      bh = 10;
    end else begin
      d0 = done_cnt;
      kbd_req = 1'b1;
      @(negedge clk);
      kbd_req = 1'b0;
      chk({tag, " R8 dropped: busy"}, busy, 0);
      repeat (3) @(negedge clk);
      chk({tag, " R8 dropped: no done"}, done_cnt, d0);
      chk({tag, " R8 dropped: busy later"}, busy, 0);
      chk({tag, " R8 dropped: kbd_port"}, kbd_port, e_port);
    end
  endtask

  task automatic pulse_retire(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); retire = 1'b1;
      @(negedge clk); retire = 1'b0;
      if (bh > 0) bh--;
    end
  endtask

  initial begin
    #1_000_000;
    chk("watchdog expired", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ret_req = 0; sw_req = 0; kbd_req = 0; retire = 0; mem_ack = 0;
    sw_vec = 0; kbd_code = 0; tbl_base = BASE; mem_rdata = 0;
    set_ctx(16'h0, 16'h0, 16'h0, 16'h0);
    e_port = 16'h0;
    mem[int'(BASE)]        = 16'd3;
    mem[int'(BASE) + 2]    = 16'hA000;
    mem[int'(BASE) + 4]    = 16'hB000;
    mem[int'(BASE) + 6]    = 16'hC000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 reset busy", busy, 0);
    chk("R9 reset done", done, 0);
    chk("R9 reset mem_req", mem_req, 0);
    chk("R9 reset kbd_port", kbd_port, 0);

    // R3 R4 R5: plain entry, no wait states
    waitst = 0;
    set_ctx(16'h0005, 16'h0040, 16'h0800, IEN | 16'h0001);
    do_sw("R5 sw vec1", 8'd1);
    chk("R4 stacked cs", rd(16'h0802), 16'h0005);
    chk("R4 stacked ip", rd(16'h0804), 16'h0040);

    // R6: return from that frame
    waitst = 1;
    set_ctx(16'h0000, 16'hB010, 16'h0804, IEN);
    do_ret("R6 return");

    // R3: last valid vector with two wait states
    waitst = 2;
    set_ctx(16'h0007, 16'h1234, 16'h0900, IEN);
    do_sw("R3 sw vec2", 8'd2);

    // R2: first out-of-range vector and the largest vector
    waitst = 0;
    set_ctx(16'h0007, 16'h1234, 16'h0900, IEN);
    do_sw("R2 sw vec3", 8'd3);
    do_sw("R2 sw vecFF", 8'hFF);

    // R1: enable clear
    set_ctx(16'h0003, 16'h0020, 16'h0A00, 16'h0001);
    do_sw("R1 sw disabled", 8'd0);

    // R7: keyboard accepted at zero hold-off
    set_ctx(16'h0002, 16'h0300, 16'h0B00, IEN);
    do_kbd("R7 kbd first", 16'h0041);

    // R8: hold-off window
    do_kbd("R8 kbd at 10", 16'h0042);
    pulse_retire(9);
    do_kbd("R8 kbd at 1", 16'h0043);
    pulse_retire(1);
    do_kbd("R7 kbd at 0", 16'h0044);
    pulse_retire(12);
    set_ctx(16'h0002, 16'h0300, 16'h0B00, 16'h0000);
    do_kbd("R8 kbd disabled", 16'h0045);

    // R10: return wins over a simultaneous software interrupt, which stays ignored
    waitst = 2;
    set_ctx(16'h0000, 16'h5000, 16'h0804, IEN);
    @(negedge clk);
    expect_acc("R10 pop ip", 16'h0804, 0, 0);
    expect_acc("R10 pop cs", 16'h0802, 0, 0);
    e_ip = rd(16'h0804); e_cs = rd(16'h0802); e_sp = 16'h0800;
    e_fl = IEN; e_fault = 1'b0;
    sw_vec = 8'd1;
    ret_req = 1'b1; sw_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 busy during held request", busy, 1);
    sw_req = 1'b0;
    wait_done("R10 priority");
    repeat (3) @(negedge clk);
    chk("R10 no second sequence", busy, 0);

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule